// File: doc/BRIEF.md
# Triggered One-Pulse Timer Channel

This block is a single-channel timer that sits idle until a rising edge arrives on an asynchronous trigger pin. The edge is resynchronised and then turns on the counter-enable. An up-counter then advances once per prescaler overflow. The channel output comes from comparing the counter against a compare value. The output can follow one of three shaping modes: two complementary PWM shapes and a toggle-on-match mode. With the one-shot option set, the counter turns itself off when it wraps at the reload value, so one trigger produces one pulse.

A fast-path option is available in the PWM shapes. With it, the trigger edge drives the output to its post-match level straight away, without waiting for the compare. This removes the counting delay from the leading edge. Software sets the block up through a small write-only register port: address 0 holds control (bit 0 one-shot, bits 3:1 shaping mode, bit 4 fast path), address 1 holds the prescale divider minus one, address 2 holds the compare value and address 3 holds the reload value. All four reset to zero.

Timing below is counted in rising clock edges, with edge 1 being the first rising edge that samples the trigger pin high. P is the prescale setting, C is the compare value and A is the reload value. The default two-flop synchroniser is assumed.

Top module: `trig_pulse_timer`

## Requirements
- R1: A rising edge on the trigger pin sets the counter-enable at edge 3, and the counter starts from zero. Counting is started by nothing other than such an edge.
- R2: With one-shot set (control bit 0 = 1), the counter-enable clears and the counter returns to 0 at the update event. The update event is a prescaler tick that finds the counter equal to the reload value. In the PWM shapes the output is then low from edge 4+(A+1)(P+1) on, and no further pulse follows.
- R3: Shaping-mode codes in control bits 3:1 are 3'b110 for PWM shape 1, 3'b111 for PWM shape 2 and 3'b001 for toggle mode. Any other code keeps the output low.
- R4: In PWM shape 2 without the fast path, the output is high while the counter is at or above the compare value. The output rises at edge 4+C(P+1) and falls at edge 4+(A+1)(P+1).
- R5: In PWM shape 1, the output is high while the counter is below the compare value. It rises at edge 4 and falls at edge 4+C(P+1).
- R6: With the fast path set (control bit 4 = 1) in PWM shape 2, the output rises at edge 3 whatever the compare value is. It stays high until edge 4+(A+1)(P+1).
- R7: The fast path has no effect in toggle mode.
- R8: In toggle mode, the output inverts at edge 4+C(P+1) on each run. It keeps its level after the counter stops.
- R9: The counter advances once every P+1 clocks, so all delays and widths scale with the prescale setting.
- R10: Trigger edges that arrive while the counter-enable is set are ignored and do not start another pulse.
- R11: With one-shot clear, the counter wraps to 0 at the update event and keeps running. The PWM output repeats with a period of (A+1)(P+1) clocks.
- R12: After reset the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select |
| wrData | input | 16 | Register write value |
| trigIn | input | 1 | Asynchronous trigger pin |
| pulseOut | output | 1 | Channel output |

## Verification
The embedded properties check several rules on every cycle. The counter-enable drops after each one-shot update and holds steady while a run is in progress. A stopped counter stays at zero. An idle PWM channel stays low. The fast strobe only fires in a PWM shape and drives shape 2 high on the next cycle. Some behaviour can only be shown by the directed scenarios, because it needs the exact edges at which the pulse starts and ends. These are the leading-edge latency with and without the fast path, the scaling by the prescaler, toggle persistence across runs, the rejection of a trigger during a run, and free-running repetition.

// File: rtl/tpt_pkg.sv
package tpt_pkg;
  localparam logic [2:0] MODE_TOGGLE = 3'b001;
  localparam logic [2:0] MODE_PWM1   = 3'b110;
  localparam logic [2:0] MODE_PWM2   = 3'b111;

  typedef struct packed {
    logic run;       // counter enable
    logic start;     // accepted trigger edge
    logic fastFire;  // force post-match level now
  } tptStrobes_t;

  function automatic logic isPwm(input logic [2:0] m);
    return (m == MODE_PWM1) || (m == MODE_PWM2);
  endfunction
endpackage

// File: rtl/tpt_ctrl.sv
module tpt_ctrl
  import tpt_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              trigIn,
  input  logic              updateEv,
  output tptStrobes_t       strobes,
  output logic [2:0]        mode,
  output logic [DATA_W-1:0] pscVal,
  output logic [DATA_W-1:0] cmpVal,
  output logic [DATA_W-1:0] arrVal
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_PSC  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_CMP  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_ARR  = ADDR_W'(3);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic                   oneShotQ, fastEnQ, cenQ, trigPrevQ;
  logic [2:0]             modeQ;
  logic [DATA_W-1:0]      pscQ, cmpQ, arrQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   edgeSeen, startNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oneShotQ <= 1'b0; fastEnQ <= 1'b0; modeQ <= 3'b000;
      pscQ <= '0; cmpQ <= '0; arrQ <= '0;
    end else if (wrEn) begin
      unique case (wrAddr)
        OFS_CTRL: begin
          oneShotQ <= wrData[0];
          modeQ    <= wrData[3:1];
          fastEnQ  <= wrData[4];
        end
        OFS_PSC: pscQ <= wrData;
        OFS_CMP: cmpQ <= wrData;
        OFS_ARR: arrQ <= wrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ     <= '0;
      trigPrevQ <= 1'b0;
    end else begin
      for (int i = SYNC_MSB; i > 0; i--) syncQ[i] <= syncQ[i-1];
      syncQ[0]  <= trigIn;
      trigPrevQ <= syncQ[SYNC_MSB];
    end
  end

  assign edgeSeen = syncQ[SYNC_MSB] & ~trigPrevQ;
  assign startNow = edgeSeen & ~cenQ;

  always_ff @(posedge clk) begin
    if (!rstN)                    cenQ <= 1'b0;
    else if (startNow)            cenQ <= 1'b1;
    else if (updateEv && oneShotQ) cenQ <= 1'b0;
  end

  always_comb begin
    strobes.run      = cenQ;
    strobes.start    = startNow;
    strobes.fastFire = startNow & fastEnQ & isPwm(modeQ);
  end

  assign mode   = modeQ;
  assign pscVal = pscQ;
  assign cmpVal = cmpQ;
  assign arrVal = arrQ;

  p_oneshot_stop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (updateEv && oneShotQ) |=> !cenQ);
  p_hold_run_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cenQ && !updateEv) |=> cenQ);
  p_start_from_edge_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cenQ) |-> $past(edgeSeen));
endmodule

// File: rtl/tpt_datapath.sv
module tpt_datapath
  import tpt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tptStrobes_t       strobes,
  input  logic [2:0]        mode,
  input  logic [DATA_W-1:0] pscVal,
  input  logic [DATA_W-1:0] cmpVal,
  input  logic [DATA_W-1:0] arrVal,
  output logic              updateEv,
  output logic              pulseOut
);
  logic [DATA_W-1:0] pscCntQ, cntQ;
  logic              tick, tickQ, fastHoldQ, outQ, outN;

  assign tick     = strobes.run && (pscCntQ == pscVal);
  assign updateEv = tick && (cntQ == arrVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pscCntQ <= '0; cntQ <= '0; tickQ <= 1'b0;
    end else begin
      tickQ <= tick;
      if (!strobes.run) begin
        pscCntQ <= '0;
        cntQ    <= '0;
      end else begin
        pscCntQ <= tick ? '0 : pscCntQ + 1'b1;
        if (tick) cntQ <= (cntQ == arrVal) ? '0 : cntQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              fastHoldQ <= 1'b0;
    else if (strobes.fastFire)              fastHoldQ <= 1'b1;
    else if (updateEv || !strobes.run)      fastHoldQ <= 1'b0;
  end

  always_comb begin
    outN = outQ;
    unique case (mode)
      MODE_PWM1: begin
        if (strobes.fastFire)  outN = 1'b0;
        else if (!strobes.run) outN = 1'b0;
        else if (fastHoldQ)    outN = 1'b0;
        else                   outN = (cntQ < cmpVal);
      end
      MODE_PWM2: begin
        if (strobes.fastFire)  outN = 1'b1;
        else if (!strobes.run) outN = 1'b0;
        else if (fastHoldQ)    outN = 1'b1;
        else                   outN = (cntQ >= cmpVal);
      end
      MODE_TOGGLE: begin
        if (strobes.run && tickQ && (cntQ == cmpVal)) outN = ~outQ;
      end
      default: outN = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outQ <= 1'b0;
    else       outQ <= outN;
  end

  assign pulseOut = outQ;

  p_idle_count_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!strobes.run) && !strobes.run) |-> (cntQ == '0));
  p_pwm_idle_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!strobes.run) && !strobes.run && isPwm(mode) && $past(isPwm(mode))) |-> !outQ);
  p_fast_pwm_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fastFire |-> isPwm(mode));
  p_fast_drives_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fastFire && mode == MODE_PWM2) |=> outQ);
endmodule

// File: rtl/trig_pulse_timer.sv
module trig_pulse_timer
  import tpt_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              trigIn,
  output logic              pulseOut
);
  tptStrobes_t       strobes;
  logic [2:0]        mode;
  logic [DATA_W-1:0] pscVal, cmpVal, arrVal;
  logic              updateEv;

  tpt_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .trigIn(trigIn), .updateEv(updateEv), .strobes(strobes), .mode(mode),
    .pscVal(pscVal), .cmpVal(cmpVal), .arrVal(arrVal)
  );

  tpt_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .mode(mode), .pscVal(pscVal),
    .cmpVal(cmpVal), .arrVal(arrVal), .updateEv(updateEv), .pulseOut(pulseOut)
  );
endmodule

// File: tb/tb_trig_pulse_timer.sv
module tb_trig_pulse_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] M_TOG = 3'b001, M_P1 = 3'b110, M_P2 = 3'b111;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, trigIn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        pulseOut;
  int checks = 0, errors = 0, edgeNo = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_pulse_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .trigIn(trigIn), .pulseOut(pulseOut)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (pulseOut !== exp) begin
      errors++;
      $display("FAIL %s edge %0d: pulseOut=%b expected %b", req, edgeNo, pulseOut, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cfg(input logic oneShot, input logic [2:0] m, input logic fast,
                     input int p, input int c, input int a);
    wr(2'd0, {11'd0, fast, m, oneShot});
    wr(2'd1, 16'(p));
    wr(2'd2, 16'(c));
    wr(2'd3, 16'(a));
  endtask

  task automatic fire();
    trigIn = 1'b1;
    edgeNo = 0;
  endtask

  task automatic stepTo(input int target);
    while (edgeNo < target) begin
      @(posedge clk);
      edgeNo++;
    end
    @(negedge clk);
  endtask

  task automatic settle();
    trigIn = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    check(1'b0, "R12 reset low");
  endtask

  task automatic t_pwm2_min();
    cfg(1'b1, M_P2, 1'b0, 0, 1, 3);
    fire();
    stepTo(4);  check(1'b0, "R4 before rise");
    stepTo(5);  check(1'b1, "R4 rise at 4+C");
    stepTo(7);  check(1'b1, "R4 still high");
    stepTo(8);  check(1'b0, "R2 fall at update");
    stepTo(30); check(1'b0, "R2 no second pulse");
    settle();
  endtask

  task automatic t_pwm2_psc();
    cfg(1'b1, M_P2, 1'b0, 2, 2, 4);
    fire();
    stepTo(9);  check(1'b0, "R9 before scaled rise");
    stepTo(10); check(1'b1, "R9 rise at 4+C(P+1)");
    stepTo(18); check(1'b1, "R9 before scaled fall");
    stepTo(19); check(1'b0, "R9 fall at 4+(A+1)(P+1)");
    settle();
  endtask

  task automatic t_pwm1();
    cfg(1'b1, M_P1, 1'b0, 1, 3, 5);
    fire();
    stepTo(3);  check(1'b0, "R5 before start");
    stepTo(4);  check(1'b1, "R5 rise at edge 4");
    stepTo(9);  check(1'b1, "R5 high while below compare");
    stepTo(10); check(1'b0, "R5 fall at 4+C(P+1)");
    stepTo(24); check(1'b0, "R2 shape 1 stopped after update");
    settle();
  endtask

  task automatic t_fast();
    cfg(1'b1, M_P2, 1'b1, 0, 3, 5);
    fire();
    stepTo(2);  check(1'b0, "R6 before fast edge");
    stepTo(3);  check(1'b1, "R6 fast rise at edge 3");
    stepTo(9);  check(1'b1, "R6 held through run");
    stepTo(10); check(1'b0, "R6 fall at update");
    settle();
  endtask

  task automatic t_toggle();
    cfg(1'b1, M_TOG, 1'b0, 0, 2, 4);
    fire();
    stepTo(5);  check(1'b0, "R8 before match");
    stepTo(6);  check(1'b1, "R8 toggle at 4+C");
    stepTo(20); check(1'b1, "R8 level kept after stop");
    settle();
    cfg(1'b1, M_TOG, 1'b1, 0, 2, 4);
    fire();
    stepTo(3);  check(1'b1, "R7 fast ignored in toggle");
    stepTo(5);  check(1'b1, "R7 no early change");
    stepTo(6);  check(1'b0, "R8 toggle back");
    settle();
  endtask

  task automatic t_badmode();
    cfg(1'b1, 3'b000, 1'b1, 0, 1, 3);
    fire();
    stepTo(3);  check(1'b0, "R3 unknown code low");
    stepTo(6);  check(1'b0, "R3 unknown code low mid-run");
    settle();
  endtask

  task automatic t_retrig();
    cfg(1'b1, M_P2, 1'b0, 0, 2, 5);
    fire();
    stepTo(3);  trigIn = 1'b0;
    stepTo(5);  trigIn = 1'b1;
    stepTo(6);  check(1'b1, "R10 pulse rises");
    stepTo(10); check(1'b0, "R10 pulse ends");
    stepTo(30); check(1'b0, "R10 mid-run edge ignored");
    settle();
  endtask

  task automatic t_cont();
    cfg(1'b0, M_P2, 1'b0, 0, 2, 3);
    fire();
    stepTo(6);  check(1'b1, "R11 first high");
    stepTo(8);  check(1'b0, "R11 wrapped low");
    stepTo(10); check(1'b1, "R11 second high");
    trigIn = 1'b0;
    wr(2'd0, {11'd0, 1'b0, M_P2, 1'b1});
    repeat (20) @(negedge clk);
    check(1'b0, "R2 stop after one-shot set");
    settle();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_pwm2_min();
    t_pwm2_psc();
    t_pwm1();
    t_fast();
    t_toggle();
    t_badmode();
    t_retrig();
    t_cont();
    summary();
  end
endmodule